// File: doc/BRIEF.md
# I2C Register-Pointer Target Port

This block is an I2C target that lets a bus controller read and write a bank of 8-bit control registers. It runs on a fast system clock. It synchronizes the SCL and SDA lines and finds their edges. From those edges it detects START and STOP conditions and shifts bytes in and out. SDA is driven through an open-drain enable: the output pulls the line low when set and releases it otherwise.

After a write address, the first byte the controller sends is a pointer byte. Its low seven bits select a register, and its top bit turns auto-increment on or off for the rest of the transaction. Any further bytes are written to the register file through a one-cycle write strobe. A read transaction cannot change the pointer. It returns data starting at the pointer that the last write left behind. The usual way to read is therefore a write that stops right after the pointer byte, followed by a read. The register file is outside this block and answers `reg_rdata` combinationally for `reg_addr`.

Top module: `i2c_regport`

## Requirements
- R1: The target acknowledges, by pulling SDA low during the ninth clock, an address byte whose upper seven bits equal binary 10010 followed by `strap[1]` and `strap[0]`. Bit 0 of that byte selects a read when it is 1 and a write when it is 0.
- R2: An address byte with any other upper seven bits gets no acknowledge, and the target does not drive SDA or write any register until the next START.
- R3: The first byte after a write address loads the register pointer from bits 6:0 and the auto-increment flag from bit 7, and the target acknowledges it.
- R4: Every later byte of a write transaction is written to the register at the pointer with `reg_we`, and the target acknowledges it.
- R5: A STOP right after the pointer byte's acknowledge writes nothing, and the pointer it loaded stays in place for a later read.
- R6: A read transaction sends the register at the pointer MSB first. A controller ACK asks for another byte. A controller NACK ends the transfer and leaves SDA released.
- R7: With auto-increment set, each byte after the first in a write or read transaction uses the next register, and the pointer wraps from 127 to 0.
- R8: With auto-increment clear, repeated bytes in a transaction all use the same register.
- R9: A START or STOP in the middle of a byte abandons that byte without writing it. After a START the target matches a fresh address.
- R10: After reset the target releases SDA, asserts no write, and holds the pointer at 0. The SDA enable changes only while SCL is low.
- R11: `reg_we` is a single-cycle pulse for each data byte written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| strap | input | 2 | Low two bits of the target address |
| reg_addr | output | 7 | Register pointer, the register-file address |
| reg_wdata | output | 8 | Data for a register write |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_rdata | input | 8 | Register-file contents at `reg_addr` |

## Verification
The assertions assume a well-behaved controller. It changes SDA only while SCL is low, except to make a START or STOP. It holds each SCL phase for several system clocks, longer than the synchronizer delay, so the target updates its SDA enable before SCL rises again. It never sends a START or STOP while the target is pulling SDA low. The bench controller has fixed phase lengths of six system clocks. It makes its mid-byte START and STOP aborts only in bytes that the controller itself is sending, so the random stimulus stays within these assumptions.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;
  localparam int DATA_W  = 8;
  localparam int PTR_W   = DATA_W - 1;
  localparam int STRAP_W = 2;
  localparam int CNT_W   = $clog2(DATA_W + 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_PTR, ST_PACK,
    ST_WDAT, ST_WACK, ST_RDAT, ST_RACK
  } tgt_state_t;

  // Address byte hits when its upper seven bits equal {fixed part, straps}
  function automatic logic addr_hit(input logic [DATA_W-1:0] b,
                                    input logic [PTR_W-STRAP_W-1:0] hi,
                                    input logic [STRAP_W-1:0] strap);
    return b[DATA_W-1:1] == {hi, strap};
  endfunction

  // Pointer advance; natural wrap at the top of the register space
  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p,
                                                input logic inc);
    return inc ? PTR_W'(p + 1'b1) : p;
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_in};
      sda_q <= {sda_q[STAGES-2:0], sda_in};
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_regport_engine.sv
module i2c_regport_engine
  import i2c_regport_pkg::*;
#(
  parameter logic [PTR_W-STRAP_W-1:0] ADDR_HI = 5'b10010
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               sda_s,
  input  logic               start_evt,
  input  logic               stop_evt,
  input  logic [STRAP_W-1:0] strap,
  input  logic [DATA_W-1:0]  rdata,
  output logic [PTR_W-1:0]   ptr,
  output logic [DATA_W-1:0]  wdata,
  output logic               we,
  output logic               sda_oe,
  output logic               ptr_load,
  output logic               busy
);
  tgt_state_t            st;
  logic [DATA_W-1:0]     sh;
  logic [CNT_W-1:0]      cnt;
  logic                  rw, inc;
  logic                  byte_done;

  assign byte_done = scl_fall && (cnt == CNT_W'(DATA_W));
  assign ptr_load  = (st == ST_PTR) && byte_done;
  assign busy      = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      sh     <= '0;
      cnt    <= '0;
      rw     <= 1'b0;
      inc    <= 1'b0;
      ptr    <= '0;
      wdata  <= '0;
      we     <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      we <= 1'b0;
      if (start_evt) begin
        st     <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_evt) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR, ST_PTR, ST_WDAT: begin
            if (scl_rise) begin
              sh  <= {sh[DATA_W-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (byte_done) begin
              if (st == ST_ADDR) begin
                if (addr_hit(sh, ADDR_HI, strap)) begin
                  rw     <= sh[0];
                  sda_oe <= 1'b1;
                  st     <= ST_AACK;
                end else begin
                  st <= ST_IDLE;
                end
              end else if (st == ST_PTR) begin
                ptr    <= sh[PTR_W-1:0];
                inc    <= sh[DATA_W-1];
                sda_oe <= 1'b1;
                st     <= ST_PACK;
              end else begin
                wdata  <= sh;
                we     <= 1'b1;
                sda_oe <= 1'b1;
                st     <= ST_WACK;
              end
            end
          end
          ST_AACK, ST_PACK, ST_WACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (st == ST_AACK && rw) begin
                sh     <= rdata;
                sda_oe <= ~rdata[DATA_W-1];
                st     <= ST_RDAT;
              end else begin
                sda_oe <= 1'b0;
                st     <= (st == ST_AACK) ? ST_PTR : ST_WDAT;
                if (st == ST_WACK) ptr <= ptr_step(ptr, inc);
              end
            end
          end
          ST_RDAT: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (byte_done) begin
              sda_oe <= 1'b0;
              st     <= ST_RACK;
            end else if (scl_fall) begin
              sda_oe <= ~sh[DATA_W-2];
              sh     <= {sh[DATA_W-2:0], 1'b0};
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              if (sda_s) st <= ST_IDLE;
              else       ptr <= ptr_step(ptr, inc);
            end else if (scl_fall) begin
              cnt    <= '0;
              sh     <= rdata;
              sda_oe <= ~rdata[DATA_W-1];
              st     <= ST_RDAT;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
  import i2c_regport_pkg::*;
#(
  parameter logic [PTR_W-STRAP_W-1:0] ADDR_HI     = 5'b10010,
  parameter int                       SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] strap,
  output logic [PTR_W-1:0]   reg_addr,
  output logic [DATA_W-1:0]  reg_wdata,
  output logic               reg_we,
  input  logic [DATA_W-1:0]  reg_rdata
);
  logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic ptr_load, busy;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2c_regport_engine #(.ADDR_HI(ADDR_HI)) u_eng (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(sda_s), .start_evt(start_evt), .stop_evt(stop_evt),
    .strap(strap), .rdata(reg_rdata), .ptr(reg_addr), .wdata(reg_wdata),
    .we(reg_we), .sda_oe(sda_oe), .ptr_load(ptr_load), .busy(busy)
  );
endmodule

// File: rtl/i2c_regport_chk.sv
module i2c_regport_chk
  import i2c_regport_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             scl_in,
  input logic             sda_oe,
  input logic             reg_we,
  input logic [PTR_W-1:0] reg_addr,
  input logic             ptr_load,
  input logic             busy
);
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_in);  // R10
  AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);  // R11
  AST_WE_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> sda_oe);  // R4
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sda_oe);  // R2
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(reg_addr) && !$past(ptr_load)) |-> reg_addr == PTR_W'($past(reg_addr) + 1'b1));  // R7
endmodule

bind i2c_regport i2c_regport_chk chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_oe(sda_oe),
  .reg_we(reg_we), .reg_addr(reg_addr), .ptr_load(ptr_load), .busy(busy)
);

// File: tb/i2c_regport_test.sv
`timescale 1ns/1ps
module i2c_regport_test;
  localparam int Q = 6;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_drv = 1'b1, sda_drv = 1'b1;
  logic [1:0] strap = 2'b01;
  logic sda_oe, reg_we;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic sda_bus;
  logic [7:0] regs [128];
  logic [7:0] model [128];
  int total = 0, bad = 0, we_cnt = 0;
  bit done = 0;

  always #4 clk = ~clk;
  assign sda_bus   = sda_drv & ~sda_oe;
  assign reg_rdata = regs[reg_addr];

  i2c_regport uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_drv), .sda_in(sda_bus),
    .sda_oe(sda_oe), .strap(strap), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  always @(posedge clk) if (reg_we) begin
    regs[reg_addr] <= reg_wdata;
    we_cnt <= we_cnt + 1;
  end

  function automatic logic [7:0] seed_val(input int i);
    return 8'((i * 7 + 3) ^ 8'h5C);
  endfunction
  function automatic logic [6:0] nxt(input logic [6:0] p, input bit inc);
    return inc ? ((p == 7'd127) ? 7'd0 : p + 7'd1) : p;
  endfunction
  function automatic logic [7:0] addr_byte(input logic [1:0] s, input bit rd);
    return {5'b10010, s, rd};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask
  task automatic bus_start;
    sda_drv = 1'b1; wq(); scl_drv = 1'b1; wq(); sda_drv = 1'b0; wq(); scl_drv = 1'b0; wq();
  endtask
  task automatic bus_stop;
    scl_drv = 1'b0; sda_drv = 1'b0; wq(); scl_drv = 1'b1; wq(); sda_drv = 1'b1; wq();
  endtask
  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_drv = b[i]; wq(); scl_drv = 1'b1; wq(2); scl_drv = 1'b0; wq();
    end
  endtask
  task automatic send_byte(input logic [7:0] b, output bit ack_n);
    send_bits(b, 8);
    sda_drv = 1'b1; wq(); scl_drv = 1'b1; wq(); ack_n = sda_bus; wq();
    scl_drv = 1'b0; wq();
  endtask
  task automatic recv_byte(output logic [7:0] d, input bit more);
    sda_drv = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl_drv = 1'b1; wq(); d[i] = sda_bus; wq(); scl_drv = 1'b0; wq();
    end
    sda_drv = more ? 1'b0 : 1'b1; wq(); scl_drv = 1'b1; wq(2); scl_drv = 1'b0; wq();
    sda_drv = 1'b1;
  endtask

  task automatic write_txn(input logic [7:0] ptrb, input logic [7:0] d[], output int nacks);
    bit a;
    nacks = 0;
    bus_start();
    send_byte(addr_byte(strap, 1'b0), a); nacks += a;
    send_byte(ptrb, a); nacks += a;
    foreach (d[k]) begin send_byte(d[k], a); nacks += a; end
    bus_stop();
  endtask
  task automatic read_txn(input int n, output logic [7:0] q[], output int nacks);
    bit a;
    q = new[n];
    bus_start();
    send_byte(addr_byte(strap, 1'b1), a); nacks = a;
    for (int k = 0; k < n; k++) recv_byte(q[k], k != n - 1);
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] q[];
    logic [7:0] d[];
    int nk, w0, mism;
    bit a;
    void'($urandom(32'd5));
    for (int i = 0; i < 128; i++) begin regs[i] = seed_val(i); model[i] = seed_val(i); end
    repeat (5) @(negedge clk);
    check(sda_oe == 0 && reg_we == 0 && reg_addr == 0, "R10 reset state", {sda_oe, reg_we, reg_addr}, 0);
    rst_n = 1'b1;
    wq(2);

    // R1 R3 R4: single write without increment
    d = new[1]; d[0] = 8'hAA;
    write_txn(8'h05, d, nk); model[5] = 8'hAA;
    check(nk == 0, "R1 R3 R4 acks on write", nk, 0);
    check(regs[5] == 8'hAA, "R4 write data", regs[5], 8'hAA);

    // R8: repeated bytes with increment clear
    d = new[3]; d[0] = 8'h11; d[1] = 8'h22; d[2] = 8'h33;
    write_txn(8'h10, d, nk); model[16] = 8'h33;
    check(regs[16] == 8'h33 && regs[17] == model[17], "R8 write same reg", regs[17], model[17]);

    // R5: pointer-only write then incrementing read
    w0 = we_cnt;
    d = new[0];
    write_txn(8'h85, d, nk);
    check(we_cnt == w0, "R5 no write on pointer-only", we_cnt, w0);
    read_txn(3, q, nk);
    check(nk == 0, "R1 read address ack", nk, 0);
    check(q[0] == model[5], "R5 R6 read from kept pointer", q[0], model[5]);
    check(q[1] == model[6] && q[2] == model[7], "R7 read increments", q[2], model[7]);

    // R8: read with increment clear
    write_txn(8'h10, d, nk);
    read_txn(2, q, nk);
    check(q[0] == 8'h33 && q[1] == 8'h33, "R8 read same reg", q[1], 8'h33);

    // R7: wrap 127 -> 0 on write and read
    d = new[3]; d[0] = 8'hC1; d[1] = 8'hC2; d[2] = 8'hC3;
    write_txn(8'hFE, d, nk);
    model[126] = 8'hC1; model[127] = 8'hC2; model[0] = 8'hC3;
    check(regs[127] == 8'hC2 && regs[0] == 8'hC3, "R7 write wraps", regs[0], 8'hC3);
    d = new[0];
    write_txn(8'hFF, d, nk);
    read_txn(2, q, nk);
    check(q[0] == 8'hC2 && q[1] == 8'hC3, "R7 read wraps", q[1], 8'hC3);

    // R2: wrong address ignored
    w0 = we_cnt; nk = 0;
    bus_start();
    send_byte(addr_byte(2'b10, 1'b0), a); nk += a;
    send_byte(8'h03, a); nk += a;
    send_byte(8'h77, a); nk += a;
    bus_stop();
    check(nk == 3, "R2 no ack for other address", nk, 3);
    check(we_cnt == w0 && regs[3] == model[3], "R2 no write", we_cnt, w0);

    // R9: STOP mid data byte, then START mid pointer byte
    w0 = we_cnt;
    bus_start();
    send_byte(addr_byte(strap, 1'b0), a);
    send_byte(8'h20, a);
    send_bits(8'hF0, 4);
    bus_stop();
    check(we_cnt == w0 && regs[32] == model[32], "R9 stop mid byte", we_cnt, w0);
    bus_start();
    send_byte(addr_byte(strap, 1'b0), a);
    send_bits(8'h21, 3);
    bus_start();
    send_byte(addr_byte(strap, 1'b0), a); nk = a;
    send_byte(8'h22, a); nk += a;
    send_byte(8'h5A, a); nk += a;
    bus_stop(); model[34] = 8'h5A;
    check(nk == 0 && regs[34] == 8'h5A, "R9 restart mid byte", regs[34], 8'h5A);

    // R1: other strap value
    strap = 2'b10;
    d = new[1]; d[0] = 8'h6E;
    write_txn(8'h40, d, nk); model[64] = 8'h6E;
    check(nk == 0 && regs[64] == 8'h6E, "R1 strap bits", regs[64], 8'h6E);

    // Random bursts: R4 R6 R7 R8
    for (int it = 0; it < 25; it++) begin
      logic [6:0] p0, p;
      bit inc;
      int len;
      p0 = 7'($urandom % 128); inc = 1'($urandom % 2); len = 1 + int'($urandom % 4);
      d = new[len];
      p = p0;
      foreach (d[k]) begin d[k] = 8'($urandom); model[p] = d[k]; p = nxt(p, inc); end
      write_txn({inc, p0}, d, nk);
      check(nk == 0, "R4 random write acks", nk, 0);
      d = new[0];
      write_txn({inc, p0}, d, nk);
      read_txn(len, q, nk);
      p = p0;
      for (int k = 0; k < len; k++) begin
        check(q[k] == model[p], inc ? "R7 random read" : "R8 random read", q[k], model[p]);
        p = nxt(p, inc);
      end
    end
    mism = 0;
    for (int i = 0; i < 128; i++) if (regs[i] !== model[i]) mism++;
    check(mism == 0, "R4 register file contents", mism, 0);
    check(sda_oe == 0, "R6 SDA released at end", sda_oe, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule